// File: doc/BRIEF.md
# SPI Master Shift Engine

This block is an 8-bit serial master that drives SCK, drives SDO and samples SDI. A transfer begins in the cycle after the host strobes a byte into the buffer register while the engine is idle. Three control bits set the transfer shape:
- the SCK idle level;
- whether SDO leads the first clock edge or changes on it;
- whether SDI is captured at mid-bit or at the end of the bit.

The bit clock is the system clock divided by 4, 16 or 64. It can instead be two pulses of an external timer tick per bit. When the eighth bit has shifted, the received byte goes into the buffer register and a sticky interrupt flag rises.

The host side is a plain register interface made of strobes with no back-pressure. `busy` shows whether the engine can accept a byte. A buffer write made while `busy` is high is dropped, and `wcol` records it. A completed byte that would overwrite an unread one is dropped instead, and `rovf` records it. In receive-only mode the output enable is released and SDO is held at 0, while bytes keep arriving with normal flag behaviour. This lets the block act as a line activity monitor.

Top module: `spi_master_core`

## Requirements
- R1: A `buf_wr` strobe while `busy` is low starts a transfer. `busy` is high from the next cycle until the edge that loads the buffer. The configuration inputs (`cfg_cpol`, `cfg_cke`, `cfg_smp`, `cfg_rate`) are captured at that strobe.
- R2: Data leaves MSB first. During bit k (k = 0..7), `sdo` carries bit 7-k of the written byte. `sdo` is 0 whenever `busy` is low.
- R3: Idle SCK equals `cfg_cpol`. Each bit time has two equal halves. With `cfg_cke`=1 the first half is at the idle level and the second half is active. With `cfg_cke`=0 the first half is active and the second half is idle.
- R4: With `cfg_smp`=0, SDI is captured at the end of the first half of each bit. With `cfg_smp`=1 it is captured at the end of the second half. The received bits fill the byte MSB first.
- R5: `cfg_rate` encoding: 0 gives 2 clocks per half-bit, 1 gives 8, 2 gives 32, and 3 gives one `tmr_tick` pulse per half-bit. A transfer lasts 16 half-bits.
- R6: At the end of the last half-bit the received byte is loaded into `buf_rdata` and `irq` rises on the same edge where `busy` falls. `irq` holds until `irq_clr`, and a new completion wins over a clear in the same cycle.
- R7: With `cfg_rx_only`=1, `sdo_oe` is 0 and `sdo` stays 0. Reception, buffer load and `irq` behave as in a normal transfer.
- R8: A `buf_wr` while `busy` is high does not disturb the running transfer and sets `wcol`. `err_clr` clears `wcol` and `rovf`, and a set in the same cycle wins.
- R9: A loaded byte stays unread until a `buf_rd` strobe. If a transfer completes while the byte is unread, `rovf` is set and `buf_rdata` keeps the older byte.
- R10: During reset `busy`, `irq`, `wcol`, `rovf`, `sdo` and `buf_rdata` are 0, `sck` equals `cfg_cpol`, and the divider counter is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cpol | input | 1 | SCK idle level |
| cfg_cke | input | 1 | 1: SDO valid before first SCK edge; 0: SDO changes on it |
| cfg_smp | input | 1 | 0: mid-bit capture; 1: end-of-bit capture |
| cfg_rate | input | 2 | Bit clock source and divider |
| cfg_rx_only | input | 1 | Release SDO and only receive |
| tmr_tick | input | 1 | External timer pulse (rate 3) |
| buf_wr | input | 1 | Buffer write strobe |
| buf_wdata | input | 8 | Byte to transmit |
| buf_rd | input | 1 | Buffer read strobe (marks byte read) |
| buf_rdata | output | 8 | Last received byte |
| irq_clr | input | 1 | Clear interrupt flag |
| err_clr | input | 1 | Clear collision and overflow flags |
| irq | output | 1 | Transfer-complete flag |
| busy | output | 1 | Transfer in progress |
| wcol | output | 1 | Write collision flag |
| rovf | output | 1 | Receive overflow flag |
| sck | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | SDO output enable |
| sdi | input | 1 | Serial data in |

## Verification
The slave stimulus drives one byte on SDI during the first half of every bit and its complement during the second half. A mid-bit capture therefore returns the byte and an end-of-bit capture returns its inverse, which exposes any sample-point mix-up. Transfers are run at every clock polarity and edge setting, at all three internal dividers and with a timer tick of odd period, so that half-bit length and SCK shape are checked apart from one another. Back-to-back transfers without a read, writes in the middle of a transfer and a receive-only transfer cover overflow retention, collision rejection and the released output.

// File: rtl/spi_master_pkg.sv
package spi_master_pkg;
  typedef enum logic [1:0] {
    RATE_DIV4  = 2'd0,
    RATE_DIV16 = 2'd1,
    RATE_DIV64 = 2'd2,
    RATE_TIMER = 2'd3
  } rate_e;

  typedef struct packed {
    logic  cpol;
    logic  cke;
    logic  smp;
    rate_e rate;
  } xfer_cfg_t;
endpackage

// File: rtl/spi_rate_gen.sv
module spi_rate_gen
  import spi_master_pkg::*;
#(
  parameter int BASE_DIV  = 4,
  parameter int STEP_LOG2 = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  run,
  input  rate_e rate,
  input  logic  tmr_tick,
  output logic  half_tick
);
  localparam int HALF_BASE = BASE_DIV / 2;
  localparam int NUM_INT   = 3;
  localparam int MAX_HALF  = HALF_BASE << ((NUM_INT - 1) * STEP_LOG2);
  localparam int PW        = $clog2(MAX_HALF) + 1;

  logic [PW-1:0] lim [NUM_INT];
  logic [PW-1:0] cnt;
  logic          hit;

  // one terminal count per internal divider
  for (genvar g = 0; g < NUM_INT; g++) begin : g_lim
    assign lim[g] = PW'((HALF_BASE << (g * STEP_LOG2)) - 1);
  end

  always_comb begin
    case (rate)
      RATE_DIV4:  hit = (cnt == lim[0]);
      RATE_DIV16: hit = (cnt == lim[1]);
      RATE_DIV64: hit = (cnt == lim[2]);
      default:    hit = tmr_tick;
    endcase
  end

  assign half_tick = run & hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   cnt <= '0;
    else if (!run || half_tick || rate == RATE_TIMER) cnt <= '0;
    else                                          cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_master_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] wdata,
  input  xfer_cfg_t     cfg_in,
  input  logic          half_tick,
  input  logic          sdi,
  output logic          busy,
  output logic          lat_cpol,
  output logic          lat_cke,
  output rate_e         lat_rate,
  output logic          sdo_bit,
  output logic          phase_b,
  output logic          done,
  output logic [DW-1:0] rx_word
);
  localparam int NH = 2 * DW;
  localparam int HW = $clog2(NH);
  localparam logic [HW-1:0] LAST = HW'(NH - 1);

  xfer_cfg_t     cfg_q;
  logic [HW-1:0] hcnt;
  logic [DW-1:0] shreg;
  logic          samp;
  logic          in_bit;

  assign in_bit   = cfg_q.smp ? sdi : samp;
  assign rx_word  = {shreg[DW-2:0], in_bit};
  assign done     = busy & half_tick & (hcnt == LAST);
  assign sdo_bit  = shreg[DW-1];
  assign phase_b  = hcnt[0];
  assign lat_cpol = cfg_q.cpol;
  assign lat_cke  = cfg_q.cke;
  assign lat_rate = cfg_q.rate;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      hcnt  <= '0;
      shreg <= '0;
      samp  <= 1'b0;
      cfg_q <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      hcnt  <= '0;
      shreg <= wdata;
      samp  <= 1'b0;
      cfg_q <= cfg_in;
    end else if (busy && half_tick) begin
      hcnt <= hcnt + 1'b1;
      if (!hcnt[0]) begin
        if (!cfg_q.smp) samp <= sdi;
      end else begin
        shreg <= rx_word;
        if (hcnt == LAST) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spi_host_regs.sv
module spi_host_regs #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          buf_wr,
  input  logic          busy,
  input  logic          buf_rd,
  input  logic          irq_clr,
  input  logic          err_clr,
  input  logic          done,
  input  logic [DW-1:0] rx_word,
  output logic [DW-1:0] rdata,
  output logic          irq,
  output logic          wcol,
  output logic          rovf
);
  logic unread;
  logic ovf_hit;
  logic load;

  assign ovf_hit = done & unread & ~buf_rd;
  assign load    = done & ~ovf_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      irq    <= 1'b0;
      wcol   <= 1'b0;
      rovf   <= 1'b0;
      unread <= 1'b0;
    end else begin
      if (load) rdata <= rx_word;

      if (load)        unread <= 1'b1;
      else if (buf_rd) unread <= 1'b0;

      if (done)         irq <= 1'b1;
      else if (irq_clr) irq <= 1'b0;

      if (buf_wr && busy) wcol <= 1'b1;
      else if (err_clr)   wcol <= 1'b0;

      if (ovf_hit)      rovf <= 1'b1;
      else if (err_clr) rovf <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_master_core.sv
module spi_master_core
  import spi_master_pkg::*;
#(
  parameter int DW        = 8,
  parameter int BASE_DIV  = 4,
  parameter int STEP_LOG2 = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_cpol,
  input  logic          cfg_cke,
  input  logic          cfg_smp,
  input  logic [1:0]    cfg_rate,
  input  logic          cfg_rx_only,
  input  logic          tmr_tick,
  input  logic          buf_wr,
  input  logic [DW-1:0] buf_wdata,
  input  logic          buf_rd,
  output logic [DW-1:0] buf_rdata,
  input  logic          irq_clr,
  input  logic          err_clr,
  output logic          irq,
  output logic          busy,
  output logic          wcol,
  output logic          rovf,
  output logic          sck,
  output logic          sdo,
  output logic          sdo_oe,
  input  logic          sdi
);
  xfer_cfg_t     cfg_in;
  logic          start;
  logic          half_tick;
  logic          lat_cpol;
  logic          lat_cke;
  rate_e         lat_rate;
  logic          sdo_bit;
  logic          phase_b;
  logic          done;
  logic [DW-1:0] rx_word;

  assign cfg_in = '{cpol: cfg_cpol, cke: cfg_cke, smp: cfg_smp, rate: rate_e'(cfg_rate)};
  assign start  = buf_wr & ~busy;

  spi_rate_gen #(.BASE_DIV(BASE_DIV), .STEP_LOG2(STEP_LOG2)) u_rate (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (busy),
    .rate      (lat_rate),
    .tmr_tick  (tmr_tick),
    .half_tick (half_tick)
  );

  spi_shift_engine #(.DW(DW)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .wdata     (buf_wdata),
    .cfg_in    (cfg_in),
    .half_tick (half_tick),
    .sdi       (sdi),
    .busy      (busy),
    .lat_cpol  (lat_cpol),
    .lat_cke   (lat_cke),
    .lat_rate  (lat_rate),
    .sdo_bit   (sdo_bit),
    .phase_b   (phase_b),
    .done      (done),
    .rx_word   (rx_word)
  );

  spi_host_regs #(.DW(DW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .buf_wr  (buf_wr),
    .busy    (busy),
    .buf_rd  (buf_rd),
    .irq_clr (irq_clr),
    .err_clr (err_clr),
    .done    (done),
    .rx_word (rx_word),
    .rdata   (buf_rdata),
    .irq     (irq),
    .wcol    (wcol),
    .rovf    (rovf)
  );

  // active level is driven in the half that matches the edge-select bit
  assign sck    = busy ? (lat_cpol ^ (phase_b == lat_cke)) : cfg_cpol;
  assign sdo    = busy & ~cfg_rx_only & sdo_bit;
  assign sdo_oe = ~cfg_rx_only;
endmodule

// File: rtl/spi_master_chk.sv
module spi_master_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          buf_wr,
  input logic          irq_clr,
  input logic          busy,
  input logic          irq,
  input logic          wcol,
  input logic          rovf,
  input logic [DW-1:0] buf_rdata
);
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_wr && !busy) |=> busy);                       // R1
  AST_WCOL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_wr && busy) |=> wcol);                        // R8
  AST_IRQ_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> irq);                              // R6
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);                        // R6
  AST_OVF_KEEPS_BUF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rovf) |-> $stable(buf_rdata));               // R9
endmodule

bind spi_master_core spi_master_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .buf_wr    (buf_wr),
  .irq_clr   (irq_clr),
  .busy      (busy),
  .irq       (irq),
  .wcol      (wcol),
  .rovf      (rovf),
  .buf_rdata (buf_rdata)
);

// File: tb/sim_spi_master_core.sv
module sim_spi_master_core;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_cpol = 1'b1, cfg_cke = 1'b0, cfg_smp = 1'b0, cfg_rx_only = 1'b0;
  logic [1:0] cfg_rate = 2'd0;
  logic tmr_tick = 1'b0, buf_wr = 1'b0, buf_rd = 1'b0, irq_clr = 1'b0, err_clr = 1'b0, sdi = 1'b0;
  logic [7:0] buf_wdata = 8'h00;
  logic [7:0] buf_rdata;
  logic irq, busy, wcol, rovf, sck, sdo, sdo_oe;

  always #(CLK_P/2) clk = ~clk;

  spi_master_core u0 (
    .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_cke(cfg_cke), .cfg_smp(cfg_smp),
    .cfg_rate(cfg_rate), .cfg_rx_only(cfg_rx_only), .tmr_tick(tmr_tick), .buf_wr(buf_wr),
    .buf_wdata(buf_wdata), .buf_rd(buf_rd), .buf_rdata(buf_rdata), .irq_clr(irq_clr),
    .err_clr(err_clr), .irq(irq), .busy(busy), .wcol(wcol), .rovf(rovf), .sck(sck),
    .sdo(sdo), .sdo_oe(sdo_oe), .sdi(sdi)
  );

  int n_vec = 0, n_err = 0, cyc = 0;
  bit tmr_en = 1'b0;
  int tcnt = 0;
  bit [7:0] slave_byte = 8'h00;

  // behavioural reference state
  bit m_busy = 0, m_irq = 0, m_wcol = 0, m_rovf = 0, m_unread = 0;
  bit m_cpol = 0, m_cke = 0, m_smp = 0;
  int m_rate = 0, m_half = 2, m_t = 0, m_h = 0;
  bit [7:0] m_tx = 0, m_rdata = 0;

  always @(posedge clk) begin
    bit tick, fin, was_busy, ovf;
    cyc++;
    if (!rst_n) begin
      m_busy = 0; m_irq = 0; m_wcol = 0; m_rovf = 0; m_unread = 0; m_rdata = 0;
      m_t = 0; m_h = 0;
    end else begin
      was_busy = m_busy;
      tick = m_busy && (m_rate == 3 ? tmr_tick : ((m_t + 1) % m_half == 0));
      fin  = tick && (m_h == 15);
      ovf  = fin && m_unread && !buf_rd;
      if (buf_wr && was_busy) m_wcol = 1; else if (err_clr) m_wcol = 0;
      if (ovf) m_rovf = 1; else if (err_clr) m_rovf = 0;
      if (fin) begin
        m_irq = 1;
        if (!ovf) begin m_rdata = m_smp ? ~slave_byte : slave_byte; m_unread = 1; end
        m_busy = 0;
      end else begin
        if (irq_clr) m_irq = 0;
        if (buf_rd) m_unread = 0;
      end
      if (m_busy) begin m_t++; if (tick) m_h++; end
      if (buf_wr && !was_busy) begin
        m_busy = 1; m_t = 0; m_h = 0; m_tx = buf_wdata;
        m_cpol = cfg_cpol; m_cke = cfg_cke; m_smp = cfg_smp; m_rate = cfg_rate;
        m_half = 2 << (2 * cfg_rate);
      end
    end
  end

  // slave and timer stimulus: first half of each bit carries the byte, second half its inverse
  always @(negedge clk) begin
    tcnt++;
    tmr_tick = tmr_en && (tcnt % 3 == 0);
    if (m_busy && m_h < 16) sdi = (m_h % 2 == 0) ? slave_byte[7 - m_h/2] : ~slave_byte[7 - m_h/2];
    else sdi = 1'b0;
  end

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (cyc > 0) begin
      bit e_sck, e_sdo;
      e_sck = m_busy ? (m_cpol ^ ((m_h % 2 == 1) == m_cke)) : cfg_cpol;
      e_sdo = (m_busy && !cfg_rx_only) ? m_tx[7 - m_h/2] : 1'b0;
      if (!rst_n) begin
        chk("R10", "sck", {7'd0, sck}, {7'd0, cfg_cpol});
        chk("R10", "busy", {7'd0, busy}, 8'd0);
        chk("R10", "flags", {5'd0, irq, wcol, rovf}, 8'd0);
        chk("R10", "sdo", {7'd0, sdo}, 8'd0);
        chk("R10", "rdata", buf_rdata, 8'd0);
      end else begin
        chk("R3", "sck", {7'd0, sck}, {7'd0, e_sck});
        chk("R2", "sdo", {7'd0, sdo}, {7'd0, e_sdo});
        chk("R7", "sdo_oe", {7'd0, sdo_oe}, {7'd0, !cfg_rx_only});
        chk("R1 R5", "busy", {7'd0, busy}, {7'd0, m_busy});
        chk("R6", "irq", {7'd0, irq}, {7'd0, m_irq});
        chk("R8", "wcol", {7'd0, wcol}, {7'd0, m_wcol});
        chk("R9", "rovf", {7'd0, rovf}, {7'd0, m_rovf});
        chk("R4", "rdata", buf_rdata, m_rdata);
      end
    end
  end

  task automatic pulse_rd();
    buf_rd = 1; @(negedge clk); buf_rd = 0;
  endtask

  task automatic xfer(input bit [7:0] tx, input bit [7:0] pat, input bit cp, input bit ck,
                      input bit sm, input bit [1:0] rt, input bit ro, input bit do_read);
    @(negedge clk);
    cfg_cpol = cp; cfg_cke = ck; cfg_smp = sm; cfg_rate = rt; cfg_rx_only = ro;
    slave_byte = pat; buf_wdata = tx; buf_wr = 1;
    @(negedge clk); buf_wr = 0;
    while (m_busy) @(negedge clk);
    if (do_read) pulse_rd();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    // R1 R2 R3 R4: idle-low, lead data, mid-bit capture, fastest rate
    xfer(8'hA5, 8'h3C, 0, 1, 0, 2'd0, 0, 1);
    // R3 R4: idle-high, data on first edge, end capture
    xfer(8'h5A, 8'hC3, 1, 0, 1, 2'd1, 0, 1);
    xfer(8'h81, 8'h7E, 1, 1, 0, 2'd0, 0, 1);
    xfer(8'h0F, 8'hE1, 0, 0, 1, 2'd0, 0, 1);
    // R5: slowest internal divider and timer tick source
    xfer(8'h96, 8'h18, 0, 1, 1, 2'd2, 0, 1);
    tmr_en = 1;
    xfer(8'h6C, 8'hB2, 1, 1, 0, 2'd3, 0, 1);
    tmr_en = 0;
    // R6: clear the interrupt flag
    irq_clr = 1; @(negedge clk); irq_clr = 0;
    // R8: write in the middle of a transfer is ignored
    @(negedge clk);
    cfg_rate = 2'd1; cfg_cke = 1; slave_byte = 8'h55; buf_wdata = 8'hC9; buf_wr = 1;
    @(negedge clk); buf_wr = 0;
    repeat (20) @(negedge clk);
    buf_wdata = 8'hFF; buf_wr = 1;
    @(negedge clk); buf_wr = 0;
    while (m_busy) @(negedge clk);
    pulse_rd();
    err_clr = 1; @(negedge clk); err_clr = 0;
    // R9: two completions with no read in between
    xfer(8'h12, 8'h9D, 0, 1, 0, 2'd0, 0, 0);
    xfer(8'h34, 8'h4B, 0, 1, 0, 2'd0, 0, 0);
    pulse_rd();
    err_clr = 1; irq_clr = 1; @(negedge clk); err_clr = 0; irq_clr = 0;
    // R7: receive-only keeps collecting bytes
    xfer(8'hFF, 8'hA7, 0, 1, 1, 2'd0, 1, 1);
    xfer(8'hFF, 8'h2D, 1, 0, 0, 2'd1, 1, 1);
    repeat (5) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      n_err++;
      $display("FAIL watchdog run did not finish actual=%0d expected=<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end
endmodule